// File: doc/BRIEF.md
# Masked content-addressable memory

The block holds a small table of words, each with a valid flag, and finds every stored word that agrees with a search argument. A global key register selects the bit positions that take part in the comparison. Positions where the key is 0 are treated as matching. All words are compared at once. The result is captured as one match bit per word.

After a search, the block steps through the captured match vector on its own, one matched word per cycle. It starts at the lowest index and shows the index with the data. It then pulses a done flag, so the requester can collect every hit without a priority encoder in its own logic.

Argument and key are loaded through their own strobes and keep their values until loaded again. A table write that arrives while a readout is still in progress discards the captured results, so the readout never returns data that the write may have changed.

Top module: `mcam_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, out_vld_o and done_o are 0. Reset clears every valid flag and sets the argument and key registers to 0.
- R2: When wr_en_i is 1 at a clock edge, wr_data_i and wr_valid_i are stored at entry wr_idx_i.
- R3: A valid entry matches when, in every bit position where the key is 1, its stored bit equals the argument bit. Positions where the key is 0 are ignored, so a key of all zeros matches every valid entry.
- R4: An entry whose valid flag is 0 never matches, whatever its data, argument and key.
- R5: When search_i is 1 at an edge and wr_en_i is 0, every entry is compared and the match vector is latched at that edge. The argument and key used are the values held before that edge. From the next cycle on, either out_vld_o or done_o is 1.
- R6: During a readout, each cycle shows one matched entry, with out_vld_o=1, out_idx_o=index and out_data_o=stored word. Entries are shown in strictly ascending index order, and each is shown exactly once.
- R7: done_o is 1 for exactly one cycle: the cycle after the last matched entry was shown. If nothing matched, it is the cycle right after the search edge. out_vld_o is 0 while done_o is 1, and both are 0 in the cycle after.
- R8: arg_ld_i loads arg_i and key_ld_i loads key_i, each on its own. A register that is not loaded keeps its value across searches.
- R9: A write during a readout clears the match vector and ends the readout: out_vld_o and done_o are 0 from the next cycle, and no done pulse follows. When wr_en_i and search_i are 1 at the same edge, the search is dropped.
- R10: A search that arrives during a readout restarts the readout from the lowest matching index of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the table |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_data_i | input | WIDTH | Word to store |
| wr_valid_i | input | 1 | Valid flag to store with the word |
| arg_ld_i | input | 1 | Load strobe for the argument register |
| arg_i | input | WIDTH | New argument value |
| key_ld_i | input | 1 | Load strobe for the key register |
| key_i | input | WIDTH | New key value (1 = compare this bit) |
| search_i | input | 1 | Start a search |
| out_vld_o | output | 1 | A matched entry is shown this cycle |
| out_idx_o | output | IDX_W | Index of the shown entry |
| out_data_o | output | WIDTH | Stored word of the shown entry |
| done_o | output | 1 | Readout finished this cycle |

## Verification
The table is loaded with two identical valid words, one distinct valid word, and one invalid entry that holds the same data as the duplicates. Then every combination of 6-bit argument and 6-bit key is searched, and each full readout sequence is compared with a match vector worked out arithmetically. The duplicates show that all hits come out in ascending order, the invalid twin separates the valid-flag gate from the data compare, and keys of all zeros and all ones cover the fully masked and fully compared extremes. Directed sequences then check the timing of register loads against a search, a write that aborts a readout, a write and a search at the same edge, and a search that restarts a readout.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/mcam_store.sv
module mcam_store #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  parameter int IDX_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WIDTH-1:0]            wr_data_i,
  input  logic                        wr_valid_i,
  output logic [WORDS-1:0][WIDTH-1:0] data_o,
  output logic [WORDS-1:0]            vld_o
);
  for (genvar i = 0; i < WORDS; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[i] <= '0;
        vld_o[i]  <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        data_o[i] <= wr_data_i;
        vld_o[i]  <= wr_valid_i;
      end
    end
  end
endmodule

// File: rtl/mcam_match.sv
module mcam_match #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9
) (
  input  logic [WORDS-1:0][WIDTH-1:0] data_i,
  input  logic [WORDS-1:0]            vld_i,
  input  logic [WIDTH-1:0]            arg_i,
  input  logic [WIDTH-1:0]            key_i,
  output logic [WORDS-1:0]            hit_o
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WIDTH-1:0] bit_ok;
    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      // equal bits, or bit excluded by key
      assign bit_ok[j] = (arg_i[j] & data_i[i][j]) | (~arg_i[j] & ~data_i[i][j]) | ~key_i[j];
    end
    assign hit_o[i] = vld_i[i] & (&bit_ok);
  end
endmodule

// File: rtl/mcam_scan.sv
module mcam_scan
  import mcam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  parameter int IDX_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        search_i,
  input  logic                        wr_en_i,
  input  logic [WORDS-1:0]            hit_i,
  input  logic [WORDS-1:0][WIDTH-1:0] data_i,
  output logic                        out_vld_o,
  output logic [IDX_W-1:0]            out_idx_o,
  output logic [WIDTH-1:0]            out_data_o,
  output logic                        done_o
);
  scan_state_e      state_q;
  logic [WORDS-1:0] match_q;
  logic [IDX_W-1:0] pick;
  logic             any;

  always_comb begin
    pick = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (match_q[i]) pick = IDX_W'(i);
    end
  end

  assign any        = |match_q;
  assign out_vld_o  = (state_q == SCAN_RUN) && any;
  assign done_o     = (state_q == SCAN_RUN) && !any;
  assign out_idx_o  = pick;
  assign out_data_o = data_i[pick];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
      match_q <= '0;
    end else if (wr_en_i) begin
      // table changed: drop stale results
      state_q <= SCAN_IDLE;
      match_q <= '0;
    end else if (search_i) begin
      state_q <= SCAN_RUN;
      match_q <= hit_i;
    end else if (state_q == SCAN_RUN) begin
      if (any) match_q[pick] <= 1'b0;
      else     state_q       <= SCAN_IDLE;
    end
  end
endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wr_valid_i,
  input  logic             arg_ld_i,
  input  logic [WIDTH-1:0] arg_i,
  input  logic             key_ld_i,
  input  logic [WIDTH-1:0] key_i,
  input  logic             search_i,
  output logic             out_vld_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic [WIDTH-1:0] out_data_o,
  output logic             done_o
);
  logic [WORDS-1:0][WIDTH-1:0] entry_data;
  logic [WORDS-1:0]            entry_vld;
  logic [WORDS-1:0]            hit;
  logic [WIDTH-1:0]            arg_q;
  logic [WIDTH-1:0]            key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q <= '0;
      key_q <= '0;
    end else begin
      if (arg_ld_i) arg_q <= arg_i;
      if (key_ld_i) key_q <= key_i;
    end
  end

  mcam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .wr_valid_i (wr_valid_i),
    .data_o     (entry_data),
    .vld_o      (entry_vld)
  );

  mcam_match #(.WORDS(WORDS), .WIDTH(WIDTH)) u_match (
    .data_i (entry_data),
    .vld_i  (entry_vld),
    .arg_i  (arg_q),
    .key_i  (key_q),
    .hit_o  (hit)
  );

  mcam_scan #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .search_i   (search_i),
    .wr_en_i    (wr_en_i),
    .hit_i      (hit),
    .data_i     (entry_data),
    .out_vld_o  (out_vld_o),
    .out_idx_o  (out_idx_o),
    .out_data_o (out_data_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/mcam_checker.sv
module mcam_checker #(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             search_i,
  input logic             wr_en_i,
  input logic             out_vld_o,
  input logic [IDX_W-1:0] out_idx_o,
  input logic             done_o,
  input logic [WORDS-1:0] entry_vld
);
  a_r7_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_vld_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !search_i) |=> (!done_o && !out_vld_o));

  a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && !search_i && !wr_en_i) |=> (!out_vld_o || (out_idx_o > $past(out_idx_o))));

  a_r9_write_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!out_vld_o && !done_o));

  a_r5_search_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search_i && !wr_en_i) |=> (out_vld_o || done_o));

  a_r4_shown_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> entry_vld[out_idx_o]);
endmodule

bind mcam_top mcam_checker #(.WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .search_i  (search_i),
  .wr_en_i   (wr_en_i),
  .out_vld_o (out_vld_o),
  .out_idx_o (out_idx_o),
  .done_o    (done_o),
  .entry_vld (entry_vld)
);

// File: tb/mcam_top_tb_top.sv
`timescale 1ns/1ps
module mcam_top_tb_top;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic          wr_valid = 1'b0;
  logic          arg_ld = 1'b0;
  logic [W-1:0]  arg = '0;
  logic          key_ld = 1'b0;
  logic [W-1:0]  key = '0;
  logic          search = 1'b0;
  logic          out_vld;
  logic [IW-1:0] out_idx;
  logic [W-1:0]  out_data;
  logic          done;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] md [N];
  logic         mv [N];

  always #2.5 clk = ~clk;

  mcam_top #(.WORDS(N), .WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .arg_ld_i(arg_ld), .arg_i(arg),
    .key_ld_i(key_ld), .key_i(key), .search_i(search), .out_vld_o(out_vld),
    .out_idx_o(out_idx), .out_data_o(out_data), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_write(input int idx, input logic [W-1:0] d, input logic v);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d; wr_valid = v;
    step();
    wr_en = 1'b0;
    md[idx] = d; mv[idx] = v;
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] k, input logic la, input logic lk);
    arg = a; key = k; arg_ld = la; key_ld = lk;
    step();
    arg_ld = 1'b0; key_ld = 1'b0;
  endtask

  task automatic do_search();
    search = 1'b1;
    step();
    search = 1'b0;
  endtask

  function automatic logic [N-1:0] model(input logic [W-1:0] a, input logic [W-1:0] k);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      r[i] = mv[i] && (((md[i] ^ a) & k) == '0);
    return r;
  endfunction

  // called right after the search edge; R6 ascending order, R7 done pulse
  task automatic expect_readout(input logic [N-1:0] exp, input string req);
    for (int i = 0; i < N; i++) begin
      if (exp[i]) begin
        chk({req, " R6 vld"}, 32'(out_vld), 32'd1);
        chk({req, " R6 idx"}, 32'(out_idx), 32'(i));
        chk({req, " R6 data"}, 32'(out_data), 32'(md[i]));
        chk({req, " R7 no done"}, 32'(done), 32'd0);
        step();
      end
    end
    chk({req, " R7 done"}, 32'(done), 32'd1);
    chk({req, " R7 vld low"}, 32'(out_vld), 32'd0);
    step();
    chk({req, " R7 done single"}, 32'(done), 32'd0);
    chk({req, " R7 idle"}, 32'(out_vld), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin md[i] = '0; mv[i] = 1'b0; end
    step(); step();
    chk("R1 reset vld", 32'(out_vld), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset vld", 32'(out_vld), 32'd0);
    chk("R1 after reset done", 32'(done), 32'd0);
    // R1: key reset to 0, all entries invalid -> done at once
    do_search();
    expect_readout('0, "R1 empty table");

    // R2 table load; entry 3 is an invalid twin of entries 0 and 1 (R4)
    do_write(0, 6'b101100, 1'b1);
    do_write(1, 6'b101100, 1'b1);
    do_write(2, 6'b010011, 1'b1);
    do_write(3, 6'b101100, 1'b1);
    do_write(3, 6'b101100, 1'b0);
    do_load(6'b101100, 6'b111111, 1'b1, 1'b1);
    do_search();
    expect_readout(4'b0011, "R2 stored words");

    // R3 R4 R5 exhaustive argument x key sweep
    for (int k = 0; k < (1 << W); k++) begin
      for (int a = 0; a < (1 << W); a++) begin
        do_load(W'(a), W'(k), 1'b1, 1'b1);
        do_search();
        expect_readout(model(W'(a), W'(k)), "R3 R4 R5 sweep");
      end
    end

    // R8 independent loads
    do_load(6'b101100, 6'b111111, 1'b1, 1'b1);
    do_load(6'b010011, 6'b000000, 1'b1, 1'b0);
    do_search();
    expect_readout(4'b0100, "R8 arg only");
    do_load(6'b111111, 6'b000000, 1'b0, 1'b1);
    do_search();
    expect_readout(4'b0111, "R8 key only");
    // R5 load at the search edge is not seen by that search
    do_load(6'b101100, 6'b111111, 1'b1, 1'b1);
    arg = 6'b010011; arg_ld = 1'b1; search = 1'b1;
    step();
    arg_ld = 1'b0; search = 1'b0;
    expect_readout(4'b0011, "R5 old argument");
    do_search();
    expect_readout(4'b0100, "R8 loaded argument");

    // R9 write aborts a readout
    do_load(6'b000000, 6'b000000, 1'b0, 1'b1);
    do_search();
    chk("R9 first shown", 32'(out_idx), 32'd0);
    do_write(2, 6'b010011, 1'b1);
    chk("R9 abort vld", 32'(out_vld), 32'd0);
    chk("R9 abort done", 32'(done), 32'd0);
    step();
    chk("R9 no late done", 32'(done), 32'd0);
    chk("R9 stays idle", 32'(out_vld), 32'd0);
    // R9 write and search together: search dropped
    search = 1'b1; wr_en = 1'b1; wr_idx = 2'd2; wr_data = 6'b010011; wr_valid = 1'b1;
    step();
    search = 1'b0; wr_en = 1'b0;
    chk("R9 dropped search vld", 32'(out_vld), 32'd0);
    chk("R9 dropped search done", 32'(done), 32'd0);

    // R10 search during readout restarts from the lowest index
    do_search();
    chk("R10 first", 32'(out_idx), 32'd0);
    step();
    chk("R10 second", 32'(out_idx), 32'd1);
    do_search();
    expect_readout(4'b0111, "R10 restart");

    finish_run();
  end
endmodule